// File: doc/BRIEF.md
# Template-Driven Bundle Dispersal Unit

This block sits between an instruction decoupling buffer and a wide execution back end. Each clock it looks at up to two bundles at the head of the buffer: a leading bundle and the one behind it. Every bundle carries three instruction slots and a 4-bit template. The block routes as many slots as it can, strictly in slot order, onto nine typed issue ports. There are two memory ports, two integer ports, two floating-point ports and three branch ports. Slot types and issue-group boundaries come only from the two templates. The instruction payloads are passed through untouched and never steer the routing.

Dispersal stops at the first slot that cannot go this cycle. That happens when every port of its type is taken, when a stop boundary closes the issue group, or when its bundle is absent or carries a reserved template. A leading bundle that is only partly issued keeps a per-slot done record, and the next cycle resumes at its first open slot. The block reports how many whole bundles it finished, so that the buffer can shift by that amount and refill the window. Port valids, payloads, slot indices and the consumed count all come from the current inputs and the done record within the same cycle.

Top module: `bundle_disperse`

## Requirements
- R1: A template splits into a pattern field in bits [1:0] and a stop field in bits [3:2]. The pattern gives the slot types for slots 0,1,2: 0 gives memory,integer,integer; 1 gives memory,memory,float; 2 gives branch,branch,branch; 3 gives memory,integer,branch. The stop field gives 0 for no stop, and 1, 2 or 3 for a stop right after slot 0, 1 or 2.
- R2: Ports are numbered 0..8 as M0,M1,I0,I1,F0,F1,B0,B1,B2. Each issued slot goes to the lowest-numbered port of its type not yet used this cycle. That port shows the slot's payload and its window index: 0..2 for leading-bundle slots and 3..5 for next-bundle slots.
- R3: When a slot's type has no free port left, that slot and every later slot in the window stay unissued for the cycle.
- R4: A stop after an issued slot ends the issue group. No later slot issues in that cycle, including slots of the next bundle.
- R5: consumedCnt is 1 when every slot of the leading bundle is issued or already done, and 2 when the next bundle is also fully issued in the same cycle. Otherwise it is 0.
- R6: Leading-bundle slots issued in a cycle that consumes nothing are marked done. When exactly one bundle is consumed, the slots issued from the next bundle become the done record of the new leading bundle. Done slots are skipped, and their stops are not applied again.
- R7: Template codes 14 and 15 are reserved. A bundle carrying one issues nothing and blocks every slot after it. A reserved next bundle still lets the leading bundle issue and be consumed.
- R8: With leadValid low, no port is valid, consumedCnt is 0 and the done record is held. With nextValid low, the next bundle is treated as absent.
- R9: While rst is high, every port valid is low and consumedCnt is 0. After a synchronous reset, the done record is empty.
- R10: An integer slot followed by a branch slot in one issue group with no stop between them both issue in the same cycle.
- R11: Payload values have no effect on which ports are valid or on consumedCnt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| leadValid | input | 1 | Leading bundle present |
| nextValid | input | 1 | Next bundle present |
| leadTmpl | input | 4 | Leading bundle template |
| nextTmpl | input | 4 | Next bundle template |
| leadSlots | input | 3*PAYLOAD_W | Leading bundle payloads, slot 0 in the low bits |
| nextSlots | input | 3*PAYLOAD_W | Next bundle payloads, slot 0 in the low bits |
| portValid | output | 9 | Per-port issue valid, bit n is port n |
| portPayload | output | 9*PAYLOAD_W | Per-port payload, port n at bits n*PAYLOAD_W |
| portSlot | output | 27 | Per-port source window index, 3 bits per port |
| consumedCnt | output | 2 | Bundles fully consumed this cycle |

## Verification
The main sweep walks every pair of leading and next templates, all 256 of them. Behind each pair it runs a short refill stream with the lead and next valids dropped on chosen cycles. This separates type-to-port mapping, oversubscription of each port class, stop placement and reserved codes, and it shows how each interacts with the done record carried across cycles. Directed sequences then isolate single effects. A stop right after slot 0 splits one bundle over two cycles. A reserved template sits in either position. Valid drops while a partial record is held. Two integer-then-branch bundles issue fully. Inverted payloads leave routing unchanged. A reset lands while a done record is held.

// File: rtl/disperse_pkg.sv
package disperse_pkg;

  localparam int BUNDLES        = 2;
  localparam int BUNDLE_SLOTS   = 3;
  localparam int WIN_SLOTS      = BUNDLES * BUNDLE_SLOTS;
  localparam int MEM_PORTS      = 2;
  localparam int INT_PORTS      = 2;
  localparam int FP_PORTS       = 2;
  localparam int BR_PORTS       = 3;
  localparam int NUM_PORTS      = MEM_PORTS + INT_PORTS + FP_PORTS + BR_PORTS;
  localparam int TMPL_W         = 4;
  localparam int PORT_IDX_W     = $clog2(NUM_PORTS);
  localparam int SLOT_IDX_W     = $clog2(WIN_SLOTS);
  localparam int RESERVED_FIRST = 14;

  localparam logic [1:0] TY_MEM = 2'd0;
  localparam logic [1:0] TY_INT = 2'd1;
  localparam logic [1:0] TY_FP  = 2'd2;
  localparam logic [1:0] TY_BR  = 2'd3;

  typedef struct packed {
    logic                          legal;
    logic [BUNDLE_SLOTS-1:0][1:0]  ty;
    logic [BUNDLE_SLOTS-1:0]       stopAfter;
  } tmplInfo_t;

  typedef struct packed {
    logic [WIN_SLOTS-1:0]                  issue;
    logic [WIN_SLOTS-1:0][PORT_IDX_W-1:0]  portSel;
    logic [1:0]                            consumed;
  } dispStrb_t;

  function automatic tmplInfo_t decodeTmpl(input logic [TMPL_W-1:0] code);
    tmplInfo_t info;
    info.legal = (code < TMPL_W'(RESERVED_FIRST));
    case (code[1:0])
      2'd0:    info.ty = {TY_INT, TY_INT, TY_MEM};
      2'd1:    info.ty = {TY_FP,  TY_MEM, TY_MEM};
      2'd2:    info.ty = {TY_BR,  TY_BR,  TY_BR};
      default: info.ty = {TY_BR,  TY_INT, TY_MEM};
    endcase
    info.stopAfter = {code[3:2] == 2'd3, code[3:2] == 2'd2, code[3:2] == 2'd1};
    return info;
  endfunction

  function automatic logic [PORT_IDX_W-1:0] portBase(input logic [1:0] ty);
    case (ty)
      TY_MEM:  return PORT_IDX_W'(0);
      TY_INT:  return PORT_IDX_W'(MEM_PORTS);
      TY_FP:   return PORT_IDX_W'(MEM_PORTS + INT_PORTS);
      default: return PORT_IDX_W'(MEM_PORTS + INT_PORTS + FP_PORTS);
    endcase
  endfunction

  function automatic logic [1:0] portCap(input logic [1:0] ty);
    case (ty)
      TY_MEM:  return 2'(MEM_PORTS);
      TY_INT:  return 2'(INT_PORTS);
      TY_FP:   return 2'(FP_PORTS);
      default: return 2'(BR_PORTS);
    endcase
  endfunction

endpackage

// File: rtl/disperse_ctrl.sv
module disperse_ctrl
  import disperse_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    leadValid,
  input  logic                    nextValid,
  input  logic [TMPL_W-1:0]       leadTmpl,
  input  logic [TMPL_W-1:0]       nextTmpl,
  input  logic [BUNDLE_SLOTS-1:0] doneLead,
  output dispStrb_t               strb
);

  tmplInfo_t              info [BUNDLES];
  logic [BUNDLES-1:0]     present;
  logic [WIN_SLOTS-1:0]   stopVec;
  logic [WIN_SLOTS-1:0]   doneVec;
  logic [3:0][1:0]        used;
  logic                   blocked;
  logic                   settledLead;
  logic                   settledNext;

  assign doneVec = {{(WIN_SLOTS-BUNDLE_SLOTS){1'b0}}, doneLead};

  // Serial left-to-right chain: each slot sees the port usage of all earlier slots
  always_comb begin
    info[0]    = decodeTmpl(leadTmpl);
    info[1]    = decodeTmpl(nextTmpl);
    present[0] = leadValid && info[0].legal;
    present[1] = leadValid && nextValid && info[1].legal;
    strb       = '0;
    used       = '0;
    blocked    = 1'b0;
    stopVec    = '0;
    for (int b = 0; b < BUNDLES; b++) begin
      for (int k = 0; k < BUNDLE_SLOTS; k++) begin
        stopVec[b*BUNDLE_SLOTS+k] = info[b].stopAfter[k];
        if (!present[b]) blocked = 1'b1;
        if (!blocked && !doneVec[b*BUNDLE_SLOTS+k]) begin
          if (used[info[b].ty[k]] < portCap(info[b].ty[k])) begin
            strb.issue[b*BUNDLE_SLOTS+k]   = 1'b1;
            strb.portSel[b*BUNDLE_SLOTS+k] = portBase(info[b].ty[k])
                                             + PORT_IDX_W'(used[info[b].ty[k]]);
            used[info[b].ty[k]] = used[info[b].ty[k]] + 2'd1;
            if (info[b].stopAfter[k]) blocked = 1'b1;
          end else begin
            blocked = 1'b1;
          end
        end
      end
    end
    settledLead   = present[0] && (&(doneLead | strb.issue[BUNDLE_SLOTS-1:0]));
    settledNext   = settledLead && present[1] && (&strb.issue[WIN_SLOTS-1:BUNDLE_SLOTS]);
    strb.consumed = settledNext ? 2'd2 : (settledLead ? 2'd1 : 2'd0);
  end

  // Issue is a gap-free prefix (done slots count as filled)
  for (genvar s = 1; s < WIN_SLOTS; s++) begin : g_chk_prefix
    p_no_gap_r3: assert property (@(posedge clk) disable iff (rst)
      strb.issue[s] |-> (strb.issue[s-1] || doneVec[s-1]));
  end

  // Nothing issues past a stop that follows an issued slot
  for (genvar s = 0; s < WIN_SLOTS - 1; s++) begin : g_chk_stop
    p_stop_ends_group_r4: assert property (@(posedge clk) disable iff (rst)
      (strb.issue[s] && stopVec[s]) |-> !strb.issue[s+1]);
  end

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !leadValid |-> (strb.issue == '0 && strb.consumed == 2'd0));

  p_two_needs_next_r5: assert property (@(posedge clk) disable iff (rst)
    (strb.consumed == 2'd2) |-> nextValid);

endmodule

// File: rtl/disperse_datapath.sv
module disperse_datapath
  import disperse_pkg::*;
#(
  parameter int PAYLOAD_W = 16
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              leadValid,
  input  dispStrb_t                         strb,
  input  logic [BUNDLE_SLOTS*PAYLOAD_W-1:0] leadSlots,
  input  logic [BUNDLE_SLOTS*PAYLOAD_W-1:0] nextSlots,
  output logic [BUNDLE_SLOTS-1:0]           doneLead,
  output logic [NUM_PORTS-1:0]              portValid,
  output logic [NUM_PORTS*PAYLOAD_W-1:0]    portPayload,
  output logic [NUM_PORTS*SLOT_IDX_W-1:0]   portSlot
);

  logic [WIN_SLOTS-1:0][PAYLOAD_W-1:0] slotPay;
  assign slotPay = {nextSlots, leadSlots};

  // Done record of the leading bundle, shifted in from the next bundle on a single consume
  always_ff @(posedge clk) begin
    if (rst) begin
      doneLead <= '0;
    end else if (leadValid) begin
      case (strb.consumed)
        2'd0:    doneLead <= doneLead | strb.issue[BUNDLE_SLOTS-1:0];
        2'd1:    doneLead <= strb.issue[WIN_SLOTS-1:BUNDLE_SLOTS];
        default: doneLead <= '0;
      endcase
    end
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic [WIN_SLOTS-1:0]  hit;
    logic                  pv;
    logic [PAYLOAD_W-1:0]  pay;
    logic [SLOT_IDX_W-1:0] src;

    always_comb begin
      hit = '0;
      pv  = 1'b0;
      pay = '0;
      src = '0;
      for (int s = 0; s < WIN_SLOTS; s++) begin
        hit[s] = strb.issue[s] && (strb.portSel[s] == PORT_IDX_W'(p));
        if (hit[s]) begin
          pv  = 1'b1;
          pay = slotPay[s];
          src = SLOT_IDX_W'(s);
        end
      end
    end

    assign portValid[p]                          = pv;
    assign portPayload[p*PAYLOAD_W +: PAYLOAD_W] = pay;
    assign portSlot[p*SLOT_IDX_W +: SLOT_IDX_W]  = src;

    p_port_single_r2: assert property (@(posedge clk) disable iff (rst)
      $countones(hit) <= 1);
  end

  p_hold_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !leadValid |=> $stable(doneLead));

  p_reset_clears_r9: assert property (@(posedge clk)
    rst |=> (doneLead == '0));

endmodule

// File: rtl/bundle_disperse.sv
module bundle_disperse
  import disperse_pkg::*;
#(
  parameter int PAYLOAD_W = 16
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              leadValid,
  input  logic                              nextValid,
  input  logic [TMPL_W-1:0]                 leadTmpl,
  input  logic [TMPL_W-1:0]                 nextTmpl,
  input  logic [BUNDLE_SLOTS*PAYLOAD_W-1:0] leadSlots,
  input  logic [BUNDLE_SLOTS*PAYLOAD_W-1:0] nextSlots,
  output logic [NUM_PORTS-1:0]              portValid,
  output logic [NUM_PORTS*PAYLOAD_W-1:0]    portPayload,
  output logic [NUM_PORTS*SLOT_IDX_W-1:0]   portSlot,
  output logic [1:0]                        consumedCnt
);

  logic                    leadLive;
  logic [BUNDLE_SLOTS-1:0] doneLead;
  dispStrb_t               strb;

  assign leadLive    = leadValid && !rst;
  assign consumedCnt = strb.consumed;

  disperse_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .leadValid (leadLive),
    .nextValid (nextValid),
    .leadTmpl  (leadTmpl),
    .nextTmpl  (nextTmpl),
    .doneLead  (doneLead),
    .strb      (strb)
  );

  disperse_datapath #(.PAYLOAD_W(PAYLOAD_W)) u_dp (
    .clk         (clk),
    .rst         (rst),
    .leadValid   (leadLive),
    .strb        (strb),
    .leadSlots   (leadSlots),
    .nextSlots   (nextSlots),
    .doneLead    (doneLead),
    .portValid   (portValid),
    .portPayload (portPayload),
    .portSlot    (portSlot)
  );

endmodule

// File: tb/bundle_disperse_bench.sv
`timescale 1ns/1ps
module bundle_disperse_bench;

  localparam int W  = 16;
  localparam int NP = 9;
  localparam int SD = 24;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          leadValid = 1'b0;
  logic          nextValid = 1'b0;
  logic [3:0]    leadTmpl = '0;
  logic [3:0]    nextTmpl = '0;
  logic [3*W-1:0] leadSlots = '0;
  logic [3*W-1:0] nextSlots = '0;
  logic [NP-1:0]   portValid;
  logic [NP*W-1:0] portPayload;
  logic [NP*3-1:0] portSlot;
  logic [1:0]      consumedCnt;

  int testsRun = 0;
  int testsFailed = 0;

  // Buffer stub: a stream of bundles, head is the leading one
  int       stT [SD];
  logic [W-1:0] stP [SD];
  int       head;
  logic [2:0] mmask;
  bit       curV0, curV1;

  always #2 clk = ~clk;

  bundle_disperse #(.PAYLOAD_W(W)) u_bundle_disperse (
    .clk(clk), .rst(rst), .leadValid(leadValid), .nextValid(nextValid),
    .leadTmpl(leadTmpl), .nextTmpl(nextTmpl), .leadSlots(leadSlots),
    .nextSlots(nextSlots), .portValid(portValid), .portPayload(portPayload),
    .portSlot(portSlot), .consumedCnt(consumedCnt)
  );

  // Slot type per R1: 0 mem, 1 int, 2 fp, 3 branch
  function automatic int slotTy(int code, int k);
    case (code % 4)
      0: return (k == 0) ? 0 : 1;
      1: return (k == 2) ? 2 : 0;
      2: return 3;
      default: return k == 0 ? 0 : (k == 1 ? 1 : 3);
    endcase
  endfunction

  function automatic int baseOf(int ty);
    return ty * 2;
  endfunction

  function automatic int capOf(int ty);
    return (ty == 3) ? 3 : 2;
  endfunction

  task automatic chk(bit ok, string tag, string what, logic [255:0] act, logic [255:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic fillStream(int t0, int t1, int payBase);
    stT[0] = t0;
    stT[1] = t1;
    for (int i = 2; i < SD; i++) stT[i] = (t0 * 3 + t1 * 5 + i * 7) % 14;
    for (int i = 0; i < SD; i++) stP[i] = W'(payBase + i * 97 + 5);
    head = 0;
  endtask

  task automatic doReset(string tag, bit check);
    @(negedge clk);
    rst = 1'b1;
    leadValid = 1'b1;
    nextValid = 1'b1;
    leadTmpl = 4'd0;
    nextTmpl = 4'd0;
    #1;
    if (check) begin
      chk(portValid == '0, tag, "port valid in reset", 256'(portValid), 256'(0));
      chk(consumedCnt == 2'd0, tag, "consumed in reset", 256'(consumedCnt), 256'(0));
    end
    @(negedge clk);
    leadValid = 1'b0;
    nextValid = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    mmask = '0;
  endtask

  // One cycle: drive, compare with model, then advance the stub and model state
  task automatic step(string tagC, string tagV, string tagP);
    logic [NP-1:0]   eV;
    logic [NP*W-1:0] ePay;
    logic [NP*3-1:0] eSlot;
    logic [5:0]      iss;
    int              cnt [4];
    bit              blocked, pres, c0, c1;
    int              code, ty, p, s, c;
    @(negedge clk);
    leadValid = curV0;
    nextValid = curV1;
    leadTmpl  = 4'(stT[head]);
    nextTmpl  = 4'(stT[head+1]);
    for (int k = 0; k < 3; k++) begin
      leadSlots[k*W +: W] = stP[head] + W'(k);
      nextSlots[k*W +: W] = stP[head+1] + W'(k);
    end
    #1;
    eV = '0; ePay = '0; eSlot = '0; iss = '0; blocked = 0;
    for (int t = 0; t < 4; t++) cnt[t] = 0;
    for (int b = 0; b < 2; b++) begin
      for (int k = 0; k < 3; k++) begin
        s = b * 3 + k;
        code = stT[head+b];
        pres = (b == 0) ? (curV0 && code < 14) : (curV0 && curV1 && code < 14);
        if (!pres) blocked = 1;
        if (!blocked && !(b == 0 && mmask[k])) begin
          ty = slotTy(code, k);
          if (cnt[ty] < capOf(ty)) begin
            p = baseOf(ty) + cnt[ty];
            cnt[ty]++;
            iss[s] = 1'b1;
            eV[p] = 1'b1;
            ePay[p*W +: W] = stP[head+b] + W'(k);
            eSlot[p*3 +: 3] = 3'(s);
            if (code / 4 == k + 1) blocked = 1;
          end else begin
            blocked = 1;
          end
        end
      end
    end
    c0 = curV0 && stT[head] < 14 && (&(mmask | iss[2:0]));
    c1 = c0 && curV1 && stT[head+1] < 14 && (&iss[5:3]);
    c  = c1 ? 2 : (c0 ? 1 : 0);
    chk(consumedCnt == 2'(c), tagC, "consumed count", 256'(consumedCnt), 256'(c));
    chk(portValid == eV, tagV, "port valid vector", 256'(portValid), 256'(eV));
    chk((portPayload & {W{1'b1}} * 0) == 0 &&
        ((portSlot == eSlot) && (portPayload == ePay)), tagP, "port slot/payload",
        256'({portSlot, portPayload}), 256'({eSlot, ePay}));
    @(posedge clk);
    if (curV0) begin
      if (c == 0) mmask = mmask | iss[2:0];
      else if (c == 1) mmask = iss[5:3];
      else mmask = '0;
      head = head + c;
    end
  endtask

  initial begin : watchdog
    #(4 * 200000);
    testsFailed++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin : main
    logic [NP-1:0] vA;
    logic [1:0]    cA;
    mmask = '0;
    curV0 = 1; curV1 = 1;

    // R9: outputs quiet in reset
    fillStream(0, 0, 0);
    doReset("R9", 1);

    // R1 / R4 / R6: stop after slot 0 splits the leading bundle over two cycles
    fillStream(4, 0, 100);
    step("R4", "R4", "R1");
    step("R6", "R6", "R6");

    // R7: reserved leading template blocks, reserved next template does not stop the lead
    doReset("R9", 0);
    fillStream(14, 0, 200);
    step("R7", "R7", "R7");
    step("R7", "R7", "R7");
    doReset("R9", 0);
    fillStream(0, 15, 300);
    step("R7", "R7", "R7");

    // R8: valid drops while a partial done record is held
    doReset("R9", 0);
    fillStream(4, 0, 400);
    step("R8", "R8", "R8");
    curV0 = 0;
    step("R8", "R8", "R8");
    step("R8", "R8", "R8");
    curV0 = 1; curV1 = 0;
    step("R8", "R8", "R8");
    curV1 = 1;

    // R10: integer then branch with no stop issue together
    doReset("R9", 0);
    fillStream(3, 3, 500);
    step("R10", "R10", "R10");

    // R11: inverted payloads keep the same routing
    doReset("R9", 0);
    fillStream(0, 1, 600);
    step("R11", "R11", "R2");
    vA = portValid; cA = consumedCnt;
    doReset("R9", 0);
    fillStream(0, 1, 600);
    for (int i = 0; i < SD; i++) stP[i] = ~stP[i];
    step("R11", "R11", "R2");
    chk(portValid == vA && consumedCnt == cA, "R11", "routing vs payload",
        256'({consumedCnt, portValid}), 256'({cA, vA}));

    // R9: reset while a done record is held restarts at slot 0
    doReset("R9", 0);
    fillStream(4, 0, 700);
    step("R9", "R9", "R9");
    doReset("R9", 0);
    head = 0;
    step("R9", "R9", "R9");

    // Sweep of all template pairs with a refill stream and valid drops
    for (int t0 = 0; t0 < 16; t0++) begin
      for (int t1 = 0; t1 < 16; t1++) begin
        doReset("R9", 0);
        fillStream(t0, t1, t0 * 16 + t1);
        for (int c = 0; c < 8; c++) begin
          curV0 = (c != 2);
          curV1 = (c != 4);
          step("R5", "R3", "R2");
        end
      end
    end

    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule